// File: doc/BRIEF.md
# Quad Mode-Select Multiplexing Latch

This block holds four independent one-bit lanes. Every lane picks a value from its two data inputs under a shared two-bit mode code and stores it. The stored value appears on a true output and a complemented output. The lane can pass data input 0, pass data input 1, pass the OR of the two inputs, or force a LOW.

Two active-low hold controls decide when a lane takes a new value. The lanes are open, and take the value the mode code picks, only while every hold control is LOW. If any hold control is HIGH, the stored value is frozen. The raising of a single control is enough to capture the data. An active-high clear overrides every other input and drives all true outputs LOW.

The block samples its inputs on a clock. Each latch is therefore a register that loads while open, and the outputs follow the inputs one cycle later. A synchronous active-low reset also clears the lanes. If the two mode lines are tied together, the block reduces to a plain two-way selector.

Top module: `quad_mux_latch`

## Requirements
- R1: While `rst_n` is LOW at a clock edge, every `q` bit is 0 and every `qn` bit is 1 after that edge.
- R2: A lane loads a new value only at an edge where all bits of `en_n` are 0. The loaded value shows on `q` right after that edge.
- R3: Mode code `sel` = 2'b00 loads `d0` into each lane.
- R4: Mode code `sel` = 2'b11 loads `d1` into each lane, so tied mode lines give a plain selector.
- R5: Mode code `sel` = 2'b01 loads `d0 | d1` into each lane.
- R6: Mode code `sel` = 2'b10 loads 0 into each lane.
- R7: At an edge where any `en_n` bit is 1, and `mr` is 0 and `rst_n` is 1, `q` keeps its value. This holds for each `en_n` bit on its own.
- R8: At an edge where `mr` is 1, `q` becomes all zeros, whatever `en_n`, `sel` and the data inputs are.
- R9: `qn` is the bitwise inverse of `q` after every edge, including during clear and hold.
- R10: If `mr` is released while some `en_n` bit is 1, `q` stays all zeros until the next edge at which all `en_n` bits are 0.
- R11: Each lane's output depends only on its own `d0`/`d1` bits. Different lanes can hold different values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 2 | Active-low hold controls; lanes are open only when all bits are 0 |
| sel | input | 2 | Mode code: 00 d0, 01 OR, 10 zero, 11 d1 |
| mr | input | 1 | Active-high clear, overrides everything except reset |
| d0 | input | 4 | Data input 0, one bit per lane |
| d1 | input | 4 | Data input 1, one bit per lane |
| q | output | 4 | True stored value per lane |
| qn | output | 4 | Complemented stored value per lane |

## Verification
Two functions can meet in one cycle: a clear on `mr` and a load through open lanes. Another case is a hold control rising in the same cycle as the mode code or data changes. The bench provokes the first by raising `mr` while both hold controls are LOW and the mode passes ones. The clear must win and the data must be ignored. It provokes the second by raising one control while changing the data, and the old value must survive. A behavioural reference model updates at every clock edge and is compared with `q` and `qn` on every cycle, including long random stretches where these cases occur naturally.

// File: rtl/qmux_pkg.sv
// Package: shared mode code for the quad multiplexing latch.
// Assumes a two-bit mode field; the values are fixed by the block's behaviour.
package qmux_pkg;
    typedef enum logic [1:0] {
        MODE_D0   = 2'b00,
        MODE_OR   = 2'b01,
        MODE_ZERO = 2'b10,
        MODE_D1   = 2'b11
    } mode_e;
endpackage

// File: rtl/qmux_lane_sel.sv
// Module: one-bit lane selector.
// Turns the two data bits of a lane into the value the mode code picks.
// Purely combinational; assumes the mode is a legal two-bit code.
module qmux_lane_sel
    import qmux_pkg::*;
(
    input  logic  d0,
    input  logic  d1,
    input  mode_e mode,
    output logic  y
);
    // Pick the lane value for the current mode.
    always_comb begin
        unique case (mode)
            MODE_D0:   y = d0;
            MODE_D1:   y = d1;
            MODE_OR:   y = d0 | d1;
            MODE_ZERO: y = 1'b0;
            default:   y = 1'b0;
        endcase
    end
endmodule

// File: rtl/qmux_hold_ctrl.sv
// Module: hold and clear decode.
// Combines N_EN active-low hold controls into one load strobe. Any control
// HIGH blocks loading. Clear wins over load.
// Assumes inputs are already synchronous to the sampling clock.
module qmux_hold_ctrl #(
    parameter int N_EN = 2
) (
    input  logic [N_EN-1:0] en_n,
    input  logic            mr,
    output logic            load,
    output logic            clear
);
    // Open only when every hold control is LOW and no clear is pending.
    always_comb begin
        clear = mr;
        load  = (en_n == '0) && !mr;
    end
endmodule

// File: rtl/qmux_store.sv
// Module: per-lane storage with true and complement copies.
// Each lane is a register that loads while open, so it acts as a sampled
// level latch. The true and complement copies are kept in separate flops.
// Assumes clear and load arrive decoded; synchronous active-low reset.
module qmux_store #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [LANES-1:0] nxt,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] qn
);
    // Update both copies of every lane: reset/clear, load, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            q  <= '0;
            qn <= '1;
        end else if (load) begin
            q  <= nxt;
            qn <= ~nxt;
        end
    end

    AST_QN_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (qn == ~q)); // R9
endmodule

// File: rtl/quad_mux_latch.sv
// Module: quad mode-select multiplexing latch (top).
// LANES independent lanes share a mode code, N_EN active-low hold
// controls and an active-high clear. Inputs are sampled on clk; outputs
// follow one cycle later. Assumes all inputs are synchronous to clk.
module quad_mux_latch
    import qmux_pkg::*;
#(
    parameter int LANES = 4,
    parameter int N_EN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EN-1:0]  en_n,
    input  logic [1:0]       sel,
    input  logic             mr,
    input  logic [LANES-1:0] d0,
    input  logic [LANES-1:0] d1,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] qn
);
    localparam logic [1:0] SEL_D0   = 2'b00;
    localparam logic [1:0] SEL_OR   = 2'b01;
    localparam logic [1:0] SEL_ZERO = 2'b10;
    localparam logic [1:0] SEL_D1   = 2'b11;

    mode_e            mode;
    logic [LANES-1:0] lane_val;
    logic             load;
    logic             clear;

    // Turn the raw mode pins into the shared mode type.
    always_comb mode = mode_e'(sel);

    // One selector per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        qmux_lane_sel u_sel (
            .d0   (d0[i]),
            .d1   (d1[i]),
            .mode (mode),
            .y    (lane_val[i])
        );
    end

    qmux_hold_ctrl #(.N_EN(N_EN)) u_ctrl (
        .en_n  (en_n),
        .mr    (mr),
        .load  (load),
        .clear (clear)
    );

    qmux_store #(.LANES(LANES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .load  (load),
        .nxt   (lane_val),
        .q     (q),
        .qn    (qn)
    );

    AST_MR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mr |=> (q == '0)); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mr && (en_n != '0)) |=> $stable(q)); // R7
    AST_MODE_D0: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mr && (en_n == '0) && sel == SEL_D0) |=> (q == $past(d0))); // R3
    AST_MODE_D1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mr && (en_n == '0) && sel == SEL_D1) |=> (q == $past(d1))); // R4
    AST_MODE_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mr && (en_n == '0) && sel == SEL_OR) |=> (q == ($past(d0) | $past(d1)))); // R5
    AST_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mr && (en_n == '0) && sel == SEL_ZERO) |=> (q == '0)); // R6
endmodule

// File: tb/tb_quad_mux_latch.sv
module tb_quad_mux_latch;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int N_EN  = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N_EN-1:0]  en_n;
    logic [1:0]       sel;
    logic             mr;
    logic [LANES-1:0] d0, d1;
    logic [LANES-1:0] q, qn;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [LANES-1:0] exp_q = '0;
    bit               model_valid = 0;
    string            cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_mux_latch #(.LANES(LANES), .N_EN(N_EN)) dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel(sel), .mr(mr),
        .d0(d0), .d1(d1), .q(q), .qn(qn)
    );

    // Behavioural reference: one stored bit per lane, updated per edge.
    always @(posedge clk) begin
        model_valid <= 1;
        if (!rst_n || mr) exp_q <= '0;
        else if (en_n == '0) begin
            for (int i = 0; i < LANES; i++) begin
                int m;
                m = int'(sel);
                if (m == 0)      exp_q[i] <= d0[i];
                else if (m == 3) exp_q[i] <= d1[i];
                else if (m == 1) exp_q[i] <= d0[i] || d1[i];
                else             exp_q[i] <= 1'b0;
            end
        end
    end

    task automatic compare();
        if (!model_valid) return;
        n_cmp++;
        if (q !== exp_q) begin
            n_bad++;
            $display("FAIL %s: q actual=%b expected=%b", cur_tag, q, exp_q);
        end
        n_cmp++;
        if (qn !== ~exp_q) begin
            n_bad++;
            $display("FAIL R9: qn actual=%b expected=%b", qn, ~exp_q);
        end
    endtask

    // Check last cycle's result, then apply new inputs.
    task automatic drive(input logic r, input logic [1:0] e, input logic [1:0] s,
                         input logic m, input logic [3:0] a, input logic [3:0] b,
                         input string tag);
        @(negedge clk);
        compare();
        rst_n = r; en_n = e; sel = s; mr = m; d0 = a; d1 = b;
        cur_tag = tag;
    endtask

    function automatic string auto_tag(logic r, logic [1:0] e, logic [1:0] s, logic m);
        if (!r) return "R1";
        if (m) return "R8";
        if (e != 2'b00) return "R7";
        case (s)
            2'b00: return "R3";
            2'b11: return "R4";
            2'b01: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 0; en_n = 0; sel = 0; mr = 0; d0 = 4'hF; d1 = 4'hF;
        // R1: reset clears even with open lanes and ones on data
        drive(0, 2'b00, 2'b00, 0, 4'hF, 4'hF, "R1");
        drive(0, 2'b00, 2'b11, 0, 4'hF, 4'hF, "R1");
        // R3 / R4 / R5 / R6 with several patterns; R11 lanes differ
        drive(1, 2'b00, 2'b00, 0, 4'b1010, 4'b0101, "R3");
        drive(1, 2'b00, 2'b11, 0, 4'b1010, 4'b0110, "R4");
        drive(1, 2'b00, 2'b01, 0, 4'b1000, 4'b0011, "R5");
        drive(1, 2'b00, 2'b10, 0, 4'hF, 4'hF, "R6");
        drive(1, 2'b00, 2'b00, 0, 4'b0110, 4'b1001, "R11");
        drive(1, 2'b00, 2'b11, 0, 4'b0110, 4'b1100, "R11");
        drive(1, 2'b00, 2'b01, 0, 4'b0000, 4'b0000, "R5");
        // R2: load resumes when both controls return LOW
        drive(1, 2'b00, 2'b00, 0, 4'b1111, 4'b0000, "R2");
        // R7: each control alone holds while data and mode change
        drive(1, 2'b01, 2'b11, 0, 4'b0000, 4'b0000, "R7");
        drive(1, 2'b01, 2'b10, 0, 4'b0000, 4'b1010, "R7");
        drive(1, 2'b00, 2'b11, 0, 4'b0000, 4'b0101, "R2");
        drive(1, 2'b10, 2'b00, 0, 4'b1010, 4'b0000, "R7");
        drive(1, 2'b10, 2'b01, 0, 4'b1111, 4'b1111, "R7");
        drive(1, 2'b11, 2'b00, 0, 4'b0011, 4'b0000, "R7");
        // R8: clear beats an open load of ones
        drive(1, 2'b00, 2'b00, 0, 4'hF, 4'hF, "R3");
        drive(1, 2'b00, 2'b01, 1, 4'hF, 4'hF, "R8");
        drive(1, 2'b00, 2'b00, 0, 4'hF, 4'hF, "R3");
        // R10: clear during hold, release, stay LOW until opened
        drive(1, 2'b01, 2'b00, 1, 4'hF, 4'hF, "R8");
        drive(1, 2'b01, 2'b00, 0, 4'hF, 4'hF, "R10");
        drive(1, 2'b10, 2'b11, 0, 4'hF, 4'hF, "R10");
        drive(1, 2'b00, 2'b11, 0, 4'b0000, 4'b1011, "R2");
        // Random stretch
        for (int k = 0; k < 400; k++) begin
            logic r, m;
            logic [1:0] e, s;
            r = ($urandom_range(0, 40) != 0);
            m = ($urandom_range(0, 12) == 0);
            e = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
            s = 2'($urandom);
            drive(r, e, s, m, 4'($urandom), 4'($urandom), auto_tag(r, e, s, m));
        end
        @(negedge clk);
        compare();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule